// File: doc/BRIEF.md
# Stereo Automatic Level Control

This block steers two 8-bit programmable-gain codes, one for the left and one for the right channel of a stereo audio path. Each code step stands for 0.5 dB. Signed samples for both channels arrive together with a valid strobe. The block compares their magnitudes against a selectable pair of levels. When either channel overloads, it pulls both target codes down. After a run of quiet samples it lifts them again in small steps, and it never lifts them past a programmed reference code.

A new target code reaches each output in one of two ways. In gated mode it waits for that channel's own sign change or for a timeout, so that gain steps land near zero crossings. In immediate mode it is applied on the same clock edge. A fast-recovery option shortens the quiet wait after an isolated single-sample overload. While the enable bit is low, both outputs simply follow the reference code.

Top module: `stereo_alc`

## Requirements
- R1: In reset both gain outputs are 0x00. While control bit 4 (enable) is 0, both outputs equal the reference code one clock later and samples have no effect.
- R2: A limiter event fires on a valid sample when either channel's magnitude is strictly above the detection level. With control bit 2 at 0 that level is 20000; with bit 2 at 1 it is 14000. Negative samples count by magnitude.
- R3: A limiter event lowers both target codes by 1 when control bit 0 is 0 and by 2 when it is 1. The result saturates at 0x00.
- R4: After a limiter event, further events stay blocked for LIM_BASE<<sel valid samples, with LIM_BASE 2 by default. The 2-bit sel comes from lim_per_imm when control bit 5 is 1 and from lim_per_zc when it is 0.
- R5: The recovery counter counts valid samples whose magnitudes are both at or below the reset level. That level is 16800 with bit 2 at 0 and 11800 with bit 2 at 1. A louder sample restarts the count. A recovery step fires on the (REC_BASE<<rec_per)-th consecutive quiet sample, 8 by default.
- R6: A recovery step raises each target by 1 when control bit 1 is 0 and by 2 when it is 1. It never raises a target above the reference code.
- R7: With control bit 3 set, a single loud sample that has quiet samples on both sides shortens the recovery wait by a right shift of FAST_SHIFT (2 samples by default). A loud run of two or more samples leaves the normal wait in place.
- R8: With control bit 5 at 0, each channel copies its target to its output only when its own sample sign bit changes between consecutive valid samples, or on timeout.
- R9: In gated mode, a target that differs from the output is applied on the (REC_BASE<<rec_per)-th valid sample of the pending period, even when no crossing occurs.
- R10: With control bit 5 at 1, a new target reaches the output on the same clock edge that computes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe for both channels |
| smp_l | input | W | Left sample, two's complement |
| smp_r | input | W | Right sample, two's complement |
| ctrl | input | 6 | Bits: 0 attenuation step, 1 recovery step, 2 level pair, 3 fast recovery, 4 enable, 5 immediate apply |
| lim_per_zc | input | 2 | Limiter spacing select in gated mode |
| lim_per_imm | input | 2 | Limiter spacing select in immediate mode |
| rec_per | input | 2 | Recovery wait and gating timeout select |
| ref_code | input | 8 | Recovery ceiling, and the output value while disabled |
| gain_l | output | 8 | Left gain code |
| gain_r | output | 8 | Right gain code |

## Verification
A recovery counter that is off by one moves the recovery step to one sample earlier or later. This shows on the gain outputs on the very sample where a step is expected, so the bench checks one sample before the boundary and again on it. A wrong cooldown count or lost impulse state shows up as a limiter or recovery step on the wrong sample within a handful of strobes. A pending target that is not tracked correctly in gated mode leaves an output stale until a crossing or timeout that should have released it, or releases it too early.

// File: rtl/stereo_alc.sv
module stereo_alc #(
  parameter int W          = 16,
  parameter int DET0       = 20000,
  parameter int RST0       = 16800,
  parameter int DET1       = 14000,
  parameter int RST1       = 11800,
  parameter int LIM_BASE   = 2,
  parameter int REC_BASE   = 8,
  parameter int FAST_SHIFT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_l,
  input  logic [W-1:0] smp_r,
  input  logic [5:0]   ctrl,
  input  logic [1:0]   lim_per_zc,
  input  logic [1:0]   lim_per_imm,
  input  logic [1:0]   rec_per,
  input  logic [7:0]   ref_code,
  output logic [7:0]   gain_l,
  output logic [7:0]   gain_r
);
  localparam int LCW = $clog2(LIM_BASE * 8 + 1);
  localparam int RCW = $clog2(REC_BASE * 8 + 1);
  localparam logic [W-1:0] D0 = W'(DET0);
  localparam logic [W-1:0] Q0 = W'(RST0);
  localparam logic [W-1:0] D1 = W'(DET1);
  localparam logic [W-1:0] Q1 = W'(RST1);

  function automatic logic [W-1:0] mag(input logic [W-1:0] s);
    return s[W-1] ? (~s + 1'b1) : s;
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] c, input logic lim, input logic rec,
                                     input logic [1:0] dn, input logic [1:0] up, input logic [7:0] rf);
    logic [8:0] s;
    s = {1'b0, c} + {7'd0, up};
    if (lim)                nxt = (c < {6'd0, dn}) ? 8'd0 : c - {6'd0, dn};
    else if (rec && c < rf) nxt = (s > {1'b0, rf}) ? rf : s[7:0];
    else                    nxt = c;
  endfunction

  wire en = ctrl[4];
  wire zc_off = ctrl[5];

  logic [7:0]     tgt_l, tgt_r;
  logic [LCW-1:0] lc;
  logic [RCW-1:0] rc, zt_l, zt_r;
  logic [1:0]     run;
  logic           imp, seen, sgn_l, sgn_r;

  wire [W-1:0] ml = mag(smp_l);
  wire [W-1:0] mr = mag(smp_r);
  wire [W-1:0] det = ctrl[2] ? D1 : D0;
  wire [W-1:0] rlv = ctrl[2] ? Q1 : Q0;
  wire over  = (ml > det) || (mr > det);
  wire quiet = (ml <= rlv) && (mr <= rlv);

  wire [LCW-1:0] lim_len  = LCW'(LIM_BASE) << (zc_off ? lim_per_imm : lim_per_zc);
  wire [RCW-1:0] rec_len  = RCW'(REC_BASE) << rec_per;
  wire [RCW-1:0] fast_raw = rec_len >> FAST_SHIFT;
  wire [RCW-1:0] fast_len = (fast_raw == '0) ? RCW'(1) : fast_raw;
  wire [RCW-1:0] rec_eff  = (ctrl[3] && imp) ? fast_len : rec_len;

  wire lim_ev = en && smp_valid && over && (lc == '0);
  wire rec_ev = en && smp_valid && quiet && (rc >= rec_eff - 1'b1) && !lim_ev;

  wire [1:0] dn = ctrl[0] ? 2'd2 : 2'd1;
  wire [1:0] up = ctrl[1] ? 2'd2 : 2'd1;
  wire [7:0] tn_l = nxt(tgt_l, lim_ev, rec_ev, dn, up, ref_code);
  wire [7:0] tn_r = nxt(tgt_r, lim_ev, rec_ev, dn, up, ref_code);

  wire pend_l = tgt_l != gain_l;
  wire pend_r = tgt_r != gain_r;
  wire to_l = pend_l && (zt_l >= rec_len - 1'b1);
  wire to_r = pend_r && (zt_r >= rec_len - 1'b1);
  wire apply_l = zc_off || (smp_valid && ((seen && smp_l[W-1] != sgn_l) || to_l));
  wire apply_r = zc_off || (smp_valid && ((seen && smp_r[W-1] != sgn_r) || to_r));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {tgt_l, tgt_r, gain_l, gain_r} <= '0;
      {lc, rc, zt_l, zt_r, run} <= '0;
      {imp, seen, sgn_l, sgn_r} <= '0;
    end else if (!en) begin
      tgt_l <= ref_code;  tgt_r <= ref_code;
      gain_l <= ref_code; gain_r <= ref_code;
      {lc, rc, zt_l, zt_r, run} <= '0;
      {imp, seen} <= '0;
    end else begin
      tgt_l <= tn_l;
      tgt_r <= tn_r;
      if (apply_l) gain_l <= tn_l;
      if (apply_r) gain_r <= tn_r;
      if (smp_valid) begin
        seen  <= 1'b1;
        sgn_l <= smp_l[W-1];
        sgn_r <= smp_r[W-1];
        lc <= lim_ev ? lim_len : (lc != '0 ? lc - 1'b1 : lc);
        rc <= (!quiet || rec_ev) ? '0 : rc + 1'b1;
        if (!quiet) begin
          run <= (run == 2'd2) ? run : run + 1'b1;
          imp <= 1'b0;
        end else begin
          if (run == 2'd1) imp <= 1'b1;
          run <= '0;
        end
        zt_l <= (apply_l || !pend_l) ? '0 : zt_l + 1'b1;
        zt_r <= (apply_r || !pend_r) ? '0 : zt_r + 1'b1;
      end
    end
  end

  assert_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_l > $past(tgt_l)) |-> (tgt_l <= $past(ref_code)));
  assert_att_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[4]) && tgt_r < $past(tgt_r)) |-> (($past(tgt_r) - tgt_r) <= 8'd2));
  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[4] |=> (gain_l == $past(ref_code) && gain_r == $past(ref_code)));
  assert_immediate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[5] |=> (gain_l == tgt_l && gain_r == tgt_r));
  assert_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[4] && lc != '0) |=> (tgt_l >= $past(tgt_l)));
endmodule

// File: tb/test_stereo_alc.sv
module test_stereo_alc;
  logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
  logic [15:0] smp_l = '0, smp_r = '0;
  logic [5:0] ctrl = '0;
  logic [1:0] lim_per_zc = '0, lim_per_imm = '0, rec_per = '0;
  logic [7:0] ref_code = 8'h90;
  logic [7:0] gain_l, gain_r;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stereo_alc i_stereo_alc (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_l(smp_l),
    .smp_r(smp_r), .ctrl(ctrl), .lim_per_zc(lim_per_zc), .lim_per_imm(lim_per_imm),
    .rec_per(rec_per), .ref_code(ref_code), .gain_l(gain_l), .gain_r(gain_r));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic snd(input int l, input int r);
    smp_l = 16'(l); smp_r = 16'(r); smp_valid = 1'b1;
    @(posedge clk); #2;
    smp_valid = 1'b0;
  endtask

  task automatic quiet_n(input int n);
    for (int i = 0; i < n; i++) snd(100, 100);
  endtask

  task automatic idle(input logic [5:0] c, input logic [7:0] rf);
    ref_code = rf; ctrl = '0;
    @(posedge clk); #2;
    ctrl = c;
  endtask

  task automatic t_reset;
    @(posedge clk); #2;
    chk("R1 reset left", gain_l, 8'h00);
    chk("R1 reset right", gain_r, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 follow ref", gain_l, 8'h90);
    snd(25000, 25000);
    chk("R1 disabled ignores sample", gain_r, 8'h90);
  endtask

  task automatic t_limit;
    idle(6'h30, 8'h90);
    snd(25000, 0);
    chk("R2 R3 R10 one step right", gain_r, 8'h8F);
    idle(6'h31, 8'h90);
    snd(0, -25000);
    chk("R2 R3 negative two step", gain_l, 8'h8E);
  endtask

  task automatic t_spacing;
    idle(6'h31, 8'h90);
    snd(25000, 0); snd(25000, 0); snd(25000, 0);
    chk("R4 blocked", gain_l, 8'h8E);
    snd(25000, 0);
    chk("R4 next event", gain_l, 8'h8C);
    lim_per_imm = 2'd1;
    idle(6'h30, 8'h90);
    for (int i = 0; i < 5; i++) snd(25000, 0);
    chk("R4 longer spacing blocked", gain_l, 8'h8F);
    snd(25000, 0);
    chk("R4 longer spacing event", gain_l, 8'h8E);
    lim_per_imm = 2'd0;
  endtask

  task automatic t_sat;
    idle(6'h31, 8'h01);
    snd(25000, 0);
    chk("R3 saturate", gain_l, 8'h00);
    snd(25000, 0); snd(25000, 0); snd(25000, 0);
    chk("R3 stays zero", gain_r, 8'h00);
  endtask

  task automatic t_recovery;
    idle(6'h30, 8'h90);
    snd(25000, 0);
    quiet_n(7);
    chk("R5 before wait ends", gain_l, 8'h8F);
    quiet_n(1);
    chk("R5 recovery step", gain_l, 8'h90);
    quiet_n(8);
    chk("R6 hold at ref", gain_r, 8'h90);
  endtask

  task automatic t_reset_level;
    idle(6'h30, 8'h90);
    snd(25000, 0);
    quiet_n(7);
    snd(18000, 0);
    chk("R2 below detect no limit", gain_l, 8'h8F);
    quiet_n(7);
    chk("R5 count restarted", gain_l, 8'h8F);
    quiet_n(1);
    chk("R5 step after restart", gain_l, 8'h90);
  endtask

  task automatic t_rstep;
    idle(6'h33, 8'hA0);
    snd(25000, 0); snd(100, 100); snd(100, 100); snd(25000, 0);
    chk("R3 two events", gain_l, 8'h9C);
    quiet_n(8);
    chk("R6 up two", gain_l, 8'h9E);
    quiet_n(8);
    chk("R6 up to ref", gain_l, 8'hA0);
    idle(6'h32, 8'h90);
    snd(25000, 0);
    quiet_n(8);
    chk("R6 clamp not 0x91", gain_r, 8'h90);
  endtask

  task automatic t_pair;
    idle(6'h30, 8'h90);
    snd(16000, 0);
    chk("R2 pair0 no event", gain_l, 8'h90);
    idle(6'h34, 8'h90);
    snd(16000, 0);
    chk("R2 pair1 event", gain_l, 8'h8F);
    quiet_n(7);
    snd(12000, 0);
    quiet_n(7);
    chk("R5 pair1 reset level", gain_l, 8'h8F);
    quiet_n(1);
    chk("R5 pair1 step", gain_l, 8'h90);
  endtask

  task automatic t_fast;
    idle(6'h38, 8'h90);
    snd(25000, 0); snd(100, 100);
    chk("R7 first quiet", gain_l, 8'h8F);
    snd(100, 100);
    chk("R7 fast step", gain_l, 8'h90);
    idle(6'h38, 8'h90);
    snd(25000, 0); snd(25000, 0);
    quiet_n(2);
    chk("R7 sustained not fast", gain_l, 8'h8F);
    quiet_n(6);
    chk("R7 sustained normal step", gain_l, 8'h90);
  endtask

  task automatic t_zc;
    idle(6'h10, 8'h90);
    snd(25000, 100);
    chk("R8 held left", gain_l, 8'h90);
    chk("R8 held right", gain_r, 8'h90);
    snd(100, -100);
    chk("R8 right crossed", gain_r, 8'h8F);
    chk("R8 left still held", gain_l, 8'h90);
    snd(-100, -100);
    chk("R8 left crossed", gain_l, 8'h8F);
  endtask

  task automatic t_timeout;
    idle(6'h10, 8'h90);
    for (int i = 0; i < 8; i++) snd(25000, 25000);
    chk("R9 before timeout", gain_l, 8'h90);
    snd(25000, 25000);
    chk("R9 timeout left", gain_l, 8'h8D);
    chk("R9 timeout right", gain_r, 8'h8D);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #3;
    t_reset;
    t_limit;
    t_spacing;
    t_sat;
    t_recovery;
    t_reset_level;
    t_rstep;
    t_pair;
    t_fast;
    t_zc;
    t_timeout;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule